// File: doc/BRIEF.md
# Touch Measurement Command Sequencer

This block replays a software-built list of touch-panel measurements against an analog front end. Software first clears the list by reading the command port, then writes switch-configuration words one at a time. Each nonzero word adds one measurement, and a zero word closes the list. When the command-select configuration input is high and the touch engine receives its start pulse, the block walks the list in order. For every entry it drives the switch-select field to the converter, waits a programmed number of 10 µs ticks for the panel to settle, and keeps sampling until a programmed number of consecutive samples agree.

Results are 12 bits wide, and each one sits in its own 16-bit lane. Measurements are grouped in pairs: the first of a pair fills the low lane and the second fills the high lane. Each pair becomes one 32-bit word in an output queue, and the consumer pops words over a valid/ready stream. When the last word of the list has been queued, the block raises a sticky touch-data-ready flag. Typical use is three pairs, with a settle count near 80 and a match count of 2.

Command words enter over a valid/ready stream. `cmd_ready` is low for the whole of a replay, so a writer must hold its word until the replay ends. On the result stream a word stays valid and unchanged until `res_ready` takes it. While the result queue is full, replay stalls before the next store.

Top module: `tsq_touch_seq`

## Requirements
- R1: After reset `busy`, `res_valid`, `overflow`, `touch_rdy`, `conv_start` and `conv_sw` are all zero, and `cmd_ready` is one.
- R2: A `cmd_rd` pulse while idle empties the list, reopens it for writes and clears `overflow`.
- R3: Each accepted nonzero command appends one entry, up to 8 entries. A nonzero write to a full, open list is dropped and sets `overflow`, which stays set until the next `cmd_rd`.
- R4: An accepted write of 0 closes the list. Nonzero writes to a closed list are dropped without setting `overflow`.
- R5: A replay starts only on an `eng_start` pulse while `cfg_cmd_sel` is 1, the list is closed and not empty, and the block is idle. Any other start pulse is ignored.
- R6: While an entry is being measured, `conv_sw[18:0]` carries bits 25..7 of its command word (bit 7 on `conv_sw[0]`: bits 7..10 pick the sampled line, 11..15 the positive reference, 16..19 the negative reference, 20..22 grounding, 23..25 supply drive). When idle, `conv_sw` is 0.
- R7: After an entry is selected, `conv_start` is not raised until `settle_lim` pulses of `tick_10us` have been counted. A `settle_lim` of 0 fires at once.
- R8: An entry's result is the first converter value that has appeared `same_lim` times in a row. A `same_lim` of 0 acts as 1.
- R9: Entry 2k goes to bits [11:0] and entry 2k+1 to bits [27:16] of result word k. Bits [15:12] and [31:28] are 0. If the list length is odd, the high lane of the last word is 0.
- R10: Result words come out in list order. A word that is valid and not accepted stays valid and unchanged.
- R11: `touch_rdy` rises in the cycle the replay completes and is cleared when the next replay is accepted.
- R12: If `cfg_cmd_sel` drops during a replay, the block returns to idle on the next clock and stores nothing further.
- R13: `cmd_ready` is 0 while `busy` is 1, and `cmd_rd` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cmd_sel | input | 1 | Command-mode select; replay runs only while this is high |
| eng_start | input | 1 | Touch engine start pulse |
| cmd_rd | input | 1 | Command-port read pulse; clears the list |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command word accepted (low during replay) |
| cmd_data | input | 32 | Command word (0 closes the list) |
| settle_lim | input | 16 | Settle wait in ticks |
| same_lim | input | 16 | Consecutive matching samples required |
| tick_10us | input | 1 | 10 µs timebase strobe |
| conv_start | output | 1 | Converter start pulse |
| conv_sw | output | 19 | Switch-select field of the current entry |
| conv_done | input | 1 | Converter sample valid |
| conv_data | input | 12 | Converter sample |
| res_valid | output | 1 | Result word valid |
| res_ready | input | 1 | Result word taken |
| res_data | output | 32 | Packed result pair |
| busy | output | 1 | Replay in progress |
| touch_rdy | output | 1 | Sticky list-complete flag |
| overflow | output | 1 | Sticky list-overflow flag |

## Verification
The assertions assume the converter raises `conv_done` only for a conversion that `conv_start` requested. They also assume `cfg_cmd_sel` is held steady while a replay runs, except in the deliberate abort case. The bench meets this with a converter model that answers each start exactly once after a fixed latency. It changes command-select only between replays, apart from one directed abort. The bench drives `res_ready` only between replays, so it also exercises the rule that a stalled result holds its value.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int CMD_W  = 32;
  localparam int SW_LSB = 7;
  localparam int SW_MSB = 25;
  localparam int SW_W   = SW_MSB - SW_LSB + 1;
  localparam int RES_W  = 12;
  localparam int LANE_W = 16;
  localparam int WORD_W = 2 * LANE_W;

  typedef enum logic [1:0] {M_IDLE, M_SETTLE, M_FIRE, M_WAIT} meas_st_t;
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_STORE} seq_st_t;
endpackage

// File: rtl/tsq_cmd_queue.sv
module tsq_cmd_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 19,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic          wr_term,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          closed,
  output logic          overflow
);
  logic [W-1:0] mem [DEPTH];
  logic         full;
  logic         append;

  assign full    = (count == CW'(DEPTH));
  assign append  = wr_en && !wr_term && !closed && !full;
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      closed   <= 1'b0;
      overflow <= 1'b0;
    end else if (clr) begin
      count    <= '0;
      closed   <= 1'b0;
      overflow <= 1'b0;
    end else if (wr_en) begin
      if (wr_term)       closed   <= 1'b1;
      else if (append)   count    <= count + CW'(1);
      else if (!closed)  overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
    end else if (append) begin
      mem[count[IW-1:0]] <= wr_data;
    end
  end
endmodule

// File: rtl/tsq_meas_timer.sv
module tsq_meas_timer
  import tsq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             abort,
  input  logic             tick,
  input  logic [CNT_W-1:0] settle_lim,
  input  logic [CNT_W-1:0] same_lim,
  output logic             conv_start,
  input  logic             conv_done,
  input  logic [DW-1:0]    conv_data,
  output logic             done,
  output logic [DW-1:0]    result
);
  meas_st_t         st;
  logic [CNT_W-1:0] scnt;
  logic [CNT_W-1:0] mcnt;
  logic [CNT_W-1:0] next_m;
  logic [CNT_W-1:0] same_eff;
  logic [DW-1:0]    lastv;
  logic             have;

  assign conv_start = (st == M_FIRE);
  assign same_eff   = (same_lim == '0) ? CNT_W'(1) : same_lim;
  assign next_m     = (have && conv_data == lastv) ? mcnt + CNT_W'(1) : CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= M_IDLE;
      scnt   <= '0;
      mcnt   <= '0;
      lastv  <= '0;
      have   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        st <= M_IDLE;
      end else begin
        case (st)
          M_IDLE: if (go) begin
            st   <= M_SETTLE;
            scnt <= '0;
            mcnt <= '0;
            have <= 1'b0;
          end
          M_SETTLE: begin
            if (scnt >= settle_lim) st <= M_FIRE;
            else if (tick)          scnt <= scnt + CNT_W'(1);
          end
          M_FIRE: st <= M_WAIT;
          M_WAIT: if (conv_done) begin
            mcnt  <= next_m;
            lastv <= conv_data;
            have  <= 1'b1;
            if (next_m >= same_eff) begin
              done   <= 1'b1;
              result <= conv_data;
              st     <= M_IDLE;
            end else begin
              st <= M_FIRE;
            end
          end
          default: st <= M_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tsq_result_fifo.sv
module tsq_result_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_pop, do_push;

  assign full      = (cnt == CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rptr];
  assign do_pop    = out_valid && out_ready;
  assign do_push   = push && !full;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wptr] <= push_data;
        wptr      <= bump(wptr);
      end
      if (do_pop) rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/tsq_touch_seq.sv
module tsq_touch_seq
  import tsq_pkg::*;
#(
  parameter int QDEPTH = 8,
  parameter int CNT_W  = 16,
  localparam int CW    = $clog2(QDEPTH + 1),
  localparam int IW    = $clog2(QDEPTH),
  localparam int RDEPTH = (QDEPTH + 1) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cmd_sel,
  input  logic              eng_start,
  input  logic              cmd_rd,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic [CNT_W-1:0]  settle_lim,
  input  logic [CNT_W-1:0]  same_lim,
  input  logic              tick_10us,
  output logic              conv_start,
  output logic [SW_W-1:0]   conv_sw,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WORD_W-1:0] res_data,
  output logic              busy,
  output logic              touch_rdy,
  output logic              overflow
);
  seq_st_t          st;
  logic [CW-1:0]    idx;
  logic [CW-1:0]    q_count;
  logic             q_closed;
  logic [SW_W-1:0]  q_sw;
  logic             go;
  logic             m_done;
  logic [RES_W-1:0] m_res;
  logic [RES_W-1:0] lo, hi;
  logic             f_full;
  logic             push;
  logic             start_ok;
  logic             last;
  logic             abort;
  logic [LANE_W-1:0] lo_lane, hi_lane;

  assign busy      = (st != S_IDLE);
  assign cmd_ready = !busy;
  assign abort     = busy && !cfg_cmd_sel;
  assign start_ok  = eng_start && cfg_cmd_sel && q_closed && (q_count != '0) && !busy;
  assign last      = ((idx + CW'(1)) == q_count);
  assign push      = (st == S_STORE) && cfg_cmd_sel && !f_full;
  assign conv_sw   = busy ? q_sw : '0;

  generate
    if (LANE_W > RES_W) begin : g_pad
      assign lo_lane = {{(LANE_W-RES_W){1'b0}}, lo};
      assign hi_lane = {{(LANE_W-RES_W){1'b0}}, hi};
    end else begin : g_nopad
      assign lo_lane = lo[LANE_W-1:0];
      assign hi_lane = hi[LANE_W-1:0];
    end
  endgenerate

  tsq_cmd_queue #(.DEPTH(QDEPTH), .W(SW_W)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cmd_rd && !busy),
    .wr_en    (cmd_valid && cmd_ready),
    .wr_term  (cmd_data == '0),
    .wr_data  (cmd_data[SW_MSB:SW_LSB]),
    .rd_idx   (idx[IW-1:0]),
    .rd_data  (q_sw),
    .count    (q_count),
    .closed   (q_closed),
    .overflow (overflow)
  );

  tsq_meas_timer #(.CNT_W(CNT_W), .DW(RES_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .abort      (abort),
    .tick       (tick_10us),
    .settle_lim (settle_lim),
    .same_lim   (same_lim),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .conv_data  (conv_data),
    .done       (m_done),
    .result     (m_res)
  );

  tsq_result_fifo #(.DEPTH(RDEPTH), .W(WORD_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data ({hi_lane, lo_lane}),
    .full      (f_full),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_data  (res_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      go        <= 1'b0;
      lo        <= '0;
      hi        <= '0;
      touch_rdy <= 1'b0;
    end else begin
      go <= 1'b0;
      case (st)
        S_IDLE: if (start_ok) begin
          st        <= S_RUN;
          idx       <= '0;
          go        <= 1'b1;
          touch_rdy <= 1'b0;
        end
        S_RUN: begin
          if (!cfg_cmd_sel) begin
            st <= S_IDLE;
          end else if (m_done) begin
            if (!idx[0]) begin
              lo <= m_res;
              if (last) begin
                hi <= '0;
                st <= S_STORE;
              end else begin
                idx <= idx + CW'(1);
                go  <= 1'b1;
              end
            end else begin
              hi <= m_res;
              st <= S_STORE;
            end
          end
        end
        S_STORE: begin
          if (!cfg_cmd_sel) begin
            st <= S_IDLE;
          end else if (!f_full) begin
            if (last) begin
              st        <= S_IDLE;
              touch_rdy <= 1'b1;
            end else begin
              idx <= idx + CW'(1);
              go  <= 1'b1;
              st  <= S_RUN;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsq_touch_seq_chk.sv
module tsq_touch_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_cmd_sel,
  input logic        cmd_rd,
  input logic        cmd_ready,
  input logic        conv_start,
  input logic [18:0] conv_sw,
  input logic        res_valid,
  input logic        res_ready,
  input logic [31:0] res_data,
  input logic        busy,
  input logic        touch_rdy,
  input logic        overflow
);
  assert_sw_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> conv_sw == '0);

  assert_fire_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !cmd_rd |=> overflow);

  assert_res_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  assert_rdy_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(touch_rdy) |-> $fell(busy));

  assert_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cfg_cmd_sel |=> !busy);

  assert_no_accept_R13: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  assert_lane_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_data[31:28] == 4'h0 && res_data[15:12] == 4'h0));
endmodule

bind tsq_touch_seq tsq_touch_seq_chk u_chk (.*);

// File: tb/tsq_touch_seq_test.sv
module tsq_touch_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_cmd_sel = 1'b0;
  logic        eng_start = 1'b0;
  logic        cmd_rd = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_data = '0;
  logic [15:0] settle_lim = 16'd2;
  logic [15:0] same_lim = 16'd2;
  logic        tick_10us = 1'b0;
  logic        conv_start;
  logic [18:0] conv_sw;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_data;
  logic        busy;
  logic        touch_rdy;
  logic        overflow;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit tick_en = 1'b1;
  logic [1:0] tcnt = '0;
  logic [1:0] lat = '0;
  logic [18:0] lat_sw = '0;
  logic [18:0] prev_sw = '0;
  logic        glitch = 1'b0;
  logic [31:0] cur [8];
  int          fires;

  always #5 clk = ~clk;

  tsq_touch_seq uut (.*);

  localparam int NV = 3;
  localparam int TBL_N [NV] = '{2, 6, 3};
  localparam logic [31:0] TBL_CMD [NV][6] = '{
    '{32'h0020_8400, 32'h0011_8100, 32'h0, 32'h0, 32'h0, 32'h0},
    '{32'h0008_8480, 32'h0001_4300, 32'h0010_8200, 32'h0020_8080, 32'h0041_0900, 32'h0082_1100},
    '{32'h0100_0180, 32'h0200_0280, 32'h0004_0480, 32'h0, 32'h0, 32'h0}
  };

  function automatic logic [11:0] model_val(input logic [18:0] sw);
    return sw[11:0] ^ 12'hA5C;
  endfunction

  function automatic logic [11:0] expv(input logic [31:0] c, input bit glitchy);
    return model_val(c[25:7]) ^ {11'b0, glitchy};
  endfunction

  always @(posedge clk) begin
    tcnt      <= tcnt + 2'd1;
    tick_10us <= tick_en && (tcnt == 2'd3);
  end

  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (lat != 2'd0) begin
      lat <= lat - 2'd1;
      if (lat == 2'd1) begin
        conv_done <= 1'b1;
        conv_data <= model_val(lat_sw) ^ {11'b0, glitch};
      end
    end
    if (conv_start) begin
      lat     <= 2'd2;
      lat_sw  <= conv_sw;
      glitch  <= (conv_sw != prev_sw);
      prev_sw <= conv_sw;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); cmd_valid = 1'b1; cmd_data = d;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic clr_list();
    @(negedge clk); cmd_rd = 1'b1;
    @(negedge clk); cmd_rd = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk); eng_start = 1'b1;
    @(negedge clk); eng_start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic drain(input int n, input bit glitchy, input string req);
    for (int w = 0; w < (n + 1) / 2; w++) begin
      logic [11:0] l, h;
      @(negedge clk);
      l = expv(cur[2*w], glitchy);
      h = (2*w + 1 < n) ? expv(cur[2*w+1], glitchy) : 12'h0;
      check(res_valid && res_data == {4'h0, h, 4'h0, l}, req, res_data, {4'h0, h, 4'h0, l});
      res_ready = 1'b1;
      @(negedge clk); res_ready = 1'b0;
    end
    @(negedge clk);
    check(!res_valid, req, {31'b0, res_valid}, 32'h0);
  endtask

  task automatic run_list(input int n);
    clr_list();
    for (int i = 0; i < n; i++) wr(cur[i]);
    wr(32'h0);
    kick();
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !res_valid && !overflow && !touch_rdy, "R1", {busy, res_valid, overflow, touch_rdy}, 32'h0);
    check(conv_sw == '0 && !conv_start && cmd_ready, "R1", {conv_sw, conv_start, cmd_ready}, 32'h1);
    rst_n = 1'b1;
    cfg_cmd_sel = 1'b1;

    // Table walk: R6 R8 R9 R10 R11
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < 6; i++) cur[i] = TBL_CMD[v][i];
      run_list(TBL_N[v]);
      check(touch_rdy, "R11", {31'b0, touch_rdy}, 32'h1);
      drain(TBL_N[v], 1'b0, "R9_R10_R8");
    end

    // R13 busy blocks writes; R11 cleared by accepted start
    kick();
    @(negedge clk);
    check(busy && !cmd_ready, "R13", {busy, cmd_ready}, 32'h2);
    check(!touch_rdy, "R11", {31'b0, touch_rdy}, 32'h0);
    // R6: conv_sw holds the first entry of list (odd list still loaded)
    check(conv_sw == cur[0][25:7], "R6", {13'b0, conv_sw}, {13'b0, cur[0][25:7]});
    cmd_rd = 1'b1; @(negedge clk); cmd_rd = 1'b0;
    wait_idle();
    drain(3, 1'b0, "R13");

    // R8 same_lim 0 acts as 1: glitched first sample kept
    same_lim = 16'd0;
    for (int i = 0; i < 2; i++) cur[i] = TBL_CMD[0][i];
    run_list(2);
    drain(2, 1'b1, "R8");
    same_lim = 16'd2;

    // R5 start ignored with command-select low
    cfg_cmd_sel = 1'b0;
    kick();
    check(!busy && !res_valid, "R5", {busy, res_valid}, 32'h0);
    cfg_cmd_sel = 1'b1;
    // R5 start ignored on an open list
    clr_list();
    wr(cur[0]);
    kick();
    check(!busy, "R5", {31'b0, busy}, 32'h0);

    // R3 overflow on 9th write; R4 writes after close dropped
    clr_list();
    for (int i = 0; i < 8; i++) begin
      cur[i] = 32'((i + 1) << 9);
      wr(cur[i]);
    end
    check(!overflow, "R3", {31'b0, overflow}, 32'h0);
    wr(32'h0000_4000);
    check(overflow, "R3", {31'b0, overflow}, 32'h1);
    wr(32'h0);
    wr(32'h0000_8000);
    check(overflow, "R4", {31'b0, overflow}, 32'h1);
    kick();
    wait_idle();
    drain(8, 1'b0, "R3_R4");
    // R2 clear empties list and drops overflow
    clr_list();
    check(!overflow, "R2", {31'b0, overflow}, 32'h0);
    kick();
    check(!busy, "R2", {31'b0, busy}, 32'h0);
    cur[0] = 32'h0002_0300;
    wr(cur[0]);
    wr(32'h0);
    wr(32'h0004_0500);
    kick();
    wait_idle();
    drain(1, 1'b0, "R4");

    // R7 settle holds conversion without ticks
    tick_en = 1'b0;
    settle_lim = 16'd3;
    kick();
    fires = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (conv_start) fires++;
    end
    check(fires == 0 && busy, "R7", 32'(fires), 32'h0);
    tick_en = 1'b1;
    wait_idle();
    drain(1, 1'b0, "R7");

    // R12 abort by dropping command select
    tick_en = 1'b0;
    kick();
    @(negedge clk);
    cfg_cmd_sel = 1'b0;
    @(negedge clk);
    check(!busy, "R12", {31'b0, busy}, 32'h0);
    repeat (10) @(negedge clk);
    check(!res_valid && !touch_rdy, "R12", {res_valid, touch_rdy}, 32'h0);
    tick_en = 1'b1;
    cfg_cmd_sel = 1'b1;
    settle_lim = 16'd0;
    kick();
    wait_idle();
    drain(1, 1'b0, "R12");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule